// File: doc/BRIEF.md
# Double-Data-Rate Pseudo-Static RAM Access Controller

This block turns single-word read and write requests from a local user port into complete transactions on an 8-bit, double-data-rate pseudo-static RAM bus. The controller clock runs at the device clock rate. In every controller cycle the block presents two bytes: one for the rising device-clock edge and one for the falling edge. The pad-level double-data-rate cells sit outside the block. They receive the byte pairs, the output enables and a clock-enable that gates the single-ended device clock. The complementary clock output is held low, because the device powers up with differential clocking switched off.

A transaction starts with a six-byte command/address phase spread over three clocks. The block then waits out a fixed initial latency and moves a single 16-bit word in one clock, using both edges. After that, chip select is released for at least one clock. The user sees busy for the whole transaction. Busy falls when the transaction ends, even if the request input is still held. A read hands its word back together with a one-cycle valid pulse.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is low: chip select is high, the clock-enable is low, busy is low, read-valid is low and the device reset output is low. The device reset output is high from the first clock after reset is released.
- R2: The 48-bit command word is built as follows. Bit 47 is 1 for a read and 0 for a write. Bit 46 is 0 (memory space). Bit 45 is 1 (linear burst). Bits 44..16 hold the word address shifted right by 3. Bits 15..3 are zero. Bits 2..0 hold the address bits 2..0.
- R3: The command word goes out on clocks 0, 1 and 2 of the transaction, with the data bus driven. The rising byte and then the falling byte of clock k carry bits 47-16k down to 32-16k.
- R4: On a write, the data word moves on clock LATENCY (clock 0 is the first command clock). The rising byte is bits 15..8, the falling byte is bits 7..0, and the strobe is driven low on that clock.
- R5: The data bus is not driven on clocks 3 to LATENCY-1. On a read the data bus and the strobe stay undriven on clock LATENCY.
- R6: On a read, the byte captured on the rising edge of clock LATENCY becomes bits 15..8 of the read data. The falling-edge byte becomes bits 7..0. Read-valid pulses high for exactly one cycle, LATENCY+2 clocks after the request is sampled.
- R7: Busy is high for LATENCY+2 cycles after the accepting edge. It then goes low for at least one cycle, even while a request stays asserted.
- R8: Chip select stays low for exactly LATENCY+1 clocks per transaction. It is high for at least one clock before the next transaction. The clock-enable is low whenever chip select is high.
- R9: A read or write request that arrives while busy is high has no effect.
- R10: If read and write are requested in the same cycle, a read is performed.
- R11: The complementary clock output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, equal to the device clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Read request, sampled when not busy |
| wr_req | input | 1 | Write request, sampled when not busy |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write word |
| busy | output | 1 | Transaction in progress |
| rdata | output | 16 | Read word |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| ck_en | output | 1 | Enables device clock toggling |
| ck_n | output | 1 | Complementary clock, tied low |
| cs_n | output | 1 | Device chip select, active low |
| dev_rst_n | output | 1 | Device reset, active low |
| dq_o_rise | output | 8 | Byte for the rising device-clock edge |
| dq_o_fall | output | 8 | Byte for the falling device-clock edge |
| dq_oe | output | 1 | Data bus output enable |
| dq_i_rise | input | 8 | Byte captured at the rising edge |
| dq_i_fall | input | 8 | Byte captured at the falling edge |
| rwds_o | output | 1 | Strobe output value |
| rwds_oe | output | 1 | Strobe output enable |

## Verification
Every word address of a 6-bit configuration is first written with a multiplicative hash pattern and then read back. The hash tells apart swapped rising/falling bytes and address aliasing. Checking every command phase against the computed word shows errors in bit placement and in the read/write flag. Held requests, requests during busy and simultaneous read-and-write requests separate correct acceptance from double starts, lost requests and wrong priority. Cycle counts taken from the request to read-valid and to busy falling catch off-by-one errors in the latency counter.

// File: rtl/psram_pkg.sv
// Shared types for the pseudo-static RAM controller.
// Assumes: a single controller clock equal to the device clock rate.
package psram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CA   = 3'd1,
        ST_WAIT = 3'd2,
        ST_DATA = 3'd3,
        ST_GAP  = 3'd4
    } ctrl_st_t;

    localparam int CA_BEATS = 3;
    localparam int CA_W     = 48;
endpackage

// File: rtl/psram_ca_fmt.sv
// Builds the 48-bit command/address word from the latched request.
// Assumes ADDR_W is between 4 and 32 (word addressing, 8 words per row
// segment in the low field).
module psram_ca_fmt #(
    parameter int ADDR_W = 22
) (
    input  logic                       is_rd,
    input  logic [ADDR_W-1:0]          addr,
    output logic [psram_pkg::CA_W-1:0] ca
);
    localparam int UP_W  = ADDR_W - 3;
    localparam int PAD_W = 29 - UP_W;

    logic [28:0] upper;

    generate
        if (PAD_W > 0) begin : g_pad
            assign upper = {{PAD_W{1'b0}}, addr[ADDR_W-1:3]};
        end else begin : g_nopad
            assign upper = addr[ADDR_W-1:3];
        end
    endgenerate

    // Field assembly: direction, space, burst type, upper and lower address
    always_comb begin
        ca = {is_rd, 1'b0, 1'b1, upper, 13'd0, addr[2:0]};
    end
endmodule

// File: rtl/psram_seq.sv
// Transaction sequencer: accepts requests, walks command, wait, data and
// gap phases, and counts device clocks from the first command clock.
// Assumes LATENCY >= CA_BEATS + 1.
module psram_seq #(
    parameter int LATENCY = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    output psram_pkg::ctrl_st_t  st,
    output logic [1:0]           beat,
    output logic                 accept,
    output logic                 is_rd
);
    import psram_pkg::*;

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LAST_CA   = CNT_W'(CA_BEATS - 1);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt;

    // Request acceptance happens only in idle
    always_comb begin
        accept = (st == ST_IDLE) && (rd_req || wr_req);
        beat   = cnt[1:0];
    end

    // State and clock counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            is_rd <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (accept) begin
                        st    <= ST_CA;
                        is_rd <= rd_req;
                    end
                end
                ST_CA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_CA) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_WAIT) st <= ST_DATA;
                end
                ST_DATA: st <= ST_GAP;
                ST_GAP:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/psram_dpath.sv
// Data path: latches the request, selects command or write bytes per
// clock, controls bus and strobe enables, captures the read word.
// Assumes the pad layer registers dq_i_rise/dq_i_fall per device clock.
module psram_dpath #(
    parameter int ADDR_W = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wdata,
    input  psram_pkg::ctrl_st_t  st,
    input  logic [1:0]           beat,
    input  logic                 is_rd,
    input  logic [psram_pkg::CA_W-1:0] ca,
    input  logic [7:0]           dq_i_rise,
    input  logic [7:0]           dq_i_fall,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [7:0]           dq_o_rise,
    output logic [7:0]           dq_o_fall,
    output logic                 dq_oe,
    output logic                 rwds_o,
    output logic                 rwds_oe,
    output logic [15:0]          rdata,
    output logic                 rvalid
);
    import psram_pkg::*;

    logic [15:0] wdata_q;

    // Latch address and write word on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Byte and enable selection for the current device clock
    always_comb begin
        dq_o_rise = 8'd0;
        dq_o_fall = 8'd0;
        dq_oe     = 1'b0;
        rwds_o    = 1'b0;
        rwds_oe   = 1'b0;
        if (st == ST_CA) begin
            dq_oe = 1'b1;
            unique case (beat)
                2'd0:    {dq_o_rise, dq_o_fall} = ca[47:32];
                2'd1:    {dq_o_rise, dq_o_fall} = ca[31:16];
                default: {dq_o_rise, dq_o_fall} = ca[15:0];
            endcase
        end else if (st == ST_DATA && !is_rd) begin
            dq_oe     = 1'b1;
            rwds_oe   = 1'b1;
            {dq_o_rise, dq_o_fall} = wdata_q;
        end
    end

    // Read word capture and one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (st == ST_DATA) && is_rd;
            if (st == ST_DATA && is_rd) rdata <= {dq_i_rise, dq_i_fall};
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
// Top: single-word double-data-rate pseudo-static RAM controller.
// Assumes controller clock equals device clock; pad cells outside the
// block turn byte pairs and enables into the bidirectional bus.
module psram_ctrl #(
    parameter int ADDR_W  = 22,
    parameter int LATENCY = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              busy,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic              ck_en,
    output logic              ck_n,
    output logic              cs_n,
    output logic              dev_rst_n,
    output logic [7:0]        dq_o_rise,
    output logic [7:0]        dq_o_fall,
    output logic              dq_oe,
    input  logic [7:0]        dq_i_rise,
    input  logic [7:0]        dq_i_fall,
    output logic              rwds_o,
    output logic              rwds_oe
);
    import psram_pkg::*;

    ctrl_st_t          st;
    logic [1:0]        beat;
    logic              accept;
    logic              is_rd;
    logic [ADDR_W-1:0] addr_q;
    logic [CA_W-1:0]   ca;

    psram_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .st(st), .beat(beat), .accept(accept), .is_rd(is_rd)
    );

    psram_ca_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .is_rd(is_rd), .addr(addr_q), .ca(ca)
    );

    psram_dpath #(.ADDR_W(ADDR_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr(addr), .wdata(wdata),
        .st(st), .beat(beat), .is_rd(is_rd), .ca(ca),
        .dq_i_rise(dq_i_rise), .dq_i_fall(dq_i_fall), .addr_q(addr_q),
        .dq_o_rise(dq_o_rise), .dq_o_fall(dq_o_fall), .dq_oe(dq_oe),
        .rwds_o(rwds_o), .rwds_oe(rwds_oe), .rdata(rdata), .rvalid(rvalid)
    );

    // Device reset follows controller reset, released one clock later
    always_ff @(posedge clk) begin
        if (!rst_n) dev_rst_n <= 1'b0;
        else        dev_rst_n <= 1'b1;
    end

    // Chip select, clock gating and busy derived from phase
    always_comb begin
        cs_n  = !(st == ST_CA || st == ST_WAIT || st == ST_DATA);
        ck_en = !cs_n;
        busy  = (st != ST_IDLE);
        ck_n  = 1'b0;
    end
endmodule

// File: rtl/psram_ctrl_chk.sv
// Protocol checker for psram_ctrl, attached by bind.
module psram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic wr_req,
    input logic busy,
    input logic rvalid,
    input logic ck_en,
    input logic ck_n,
    input logic cs_n,
    input logic dq_oe,
    input logic rwds_oe,
    input logic rwds_o
);
    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_req || wr_req)) |=> busy);
    // R6
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
    // R8
    ck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !ck_en);
    // R5
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe || rwds_oe) |-> !cs_n);
    // R4
    strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwds_oe |-> (!rwds_o && dq_oe));
    // R11
    ck_n_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_n);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (cs_n && !busy && !rvalid));
endmodule

bind psram_ctrl psram_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .busy(busy), .rvalid(rvalid), .ck_en(ck_en), .ck_n(ck_n),
    .cs_n(cs_n), .dq_oe(dq_oe), .rwds_oe(rwds_oe), .rwds_o(rwds_o)
);

// File: tb/test_psram_ctrl.sv
// Self-checking bench: device model plus full address sweep on a small
// configuration.
module test_psram_ctrl;
    localparam int AW  = 6;
    localparam int LAT = 12;
    localparam int NW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          busy, rvalid, ck_en, ck_n, cs_n, dev_rst_n;
    logic [15:0]   rdata;
    logic [7:0]    dq_o_rise, dq_o_fall, dq_i_rise, dq_i_fall;
    logic          dq_oe, rwds_o, rwds_oe;

    int tests = 0, fails = 0;
    logic [15:0] mem [NW];
    logic        exp_rd = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    int  idx = 0, cs_low = 0, txn = 0;
    logic cs_prev = 1'b1;

    always #5 clk = ~clk;

    psram_ctrl #(.ADDR_W(AW), .LATENCY(LAT)) i_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .wdata(wdata), .busy(busy), .rdata(rdata),
        .rvalid(rvalid), .ck_en(ck_en), .ck_n(ck_n), .cs_n(cs_n),
        .dev_rst_n(dev_rst_n), .dq_o_rise(dq_o_rise), .dq_o_fall(dq_o_fall),
        .dq_oe(dq_oe), .dq_i_rise(dq_i_rise), .dq_i_fall(dq_i_fall),
        .rwds_o(rwds_o), .rwds_oe(rwds_oe)
    );

    task automatic chk(input logic ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] ca_word(input logic rd, input logic [AW-1:0] a);
        logic [28:0] up;
        up = 29'(a >> 3);
        return {rd, 1'b0, 1'b1, up, 13'd0, a[2:0]};
    endfunction

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 40503) ^ 16'hC3A5);
    endfunction

    // Device model: checks command bytes, stores writes, returns reads
    always @(negedge clk) begin
        logic [47:0] cw;
        chk(ck_n == 1'b0, "R11", 48'(ck_n), 0);
        chk(ck_en == !cs_n, "R8", 48'(ck_en), 48'(!cs_n));
        if (!cs_n) begin
            if (cs_prev) begin idx = 0; cs_low = 0; txn++; end
            cs_low++;
            cw = ca_word(exp_rd, exp_addr);
            if (idx < 3) begin
                chk(dq_oe, "R3", 48'(dq_oe), 1);
                chk({dq_o_rise, dq_o_fall} == cw[47-16*idx -: 16], "R2",
                    48'({dq_o_rise, dq_o_fall}), 48'(cw[47-16*idx -: 16]));
            end else if (idx < LAT) begin
                chk(!dq_oe, "R5", 48'(dq_oe), 0);
            end else if (idx == LAT) begin
                if (exp_rd) begin
                    chk(!dq_oe && !rwds_oe, "R5", 48'({dq_oe, rwds_oe}), 0);
                    {dq_i_rise, dq_i_fall} = mem[exp_addr];
                end else begin
                    chk(dq_oe && rwds_oe && !rwds_o, "R4",
                        48'({dq_oe, rwds_oe, rwds_o}), 48'b110);
                    mem[exp_addr] = {dq_o_rise, dq_o_fall};
                end
            end
            idx++;
        end else if (!cs_prev) begin
            chk(cs_low == LAT + 1, "R8", 48'(cs_low), 48'(LAT + 1));
        end
        cs_prev = cs_n;
    end

    // One transaction; returns negedges until busy falls and rvalid seen
    task automatic xfer(input logic rd, input logic wr, input logic [AW-1:0] a,
                        input logic [15:0] d, output int t_done, output int t_val,
                        output logic [15:0] got);
        exp_rd = rd; exp_addr = a;
        rd_req = rd; wr_req = wr; addr = a; wdata = d;
        t_done = 0; t_val = 0; got = '0;
        for (int n = 1; n < 40; n++) begin
            @(negedge clk);
            if (n == 1) begin
                rd_req = 1'b0; wr_req = 1'b0;
                chk(busy, "R7", 48'(busy), 1);
            end
            if (rvalid) begin t_val = n; got = rdata; end
            if (!busy) begin t_done = n; break; end
        end
    endtask

    initial begin
        int td, tv, c0;
        logic [15:0] g;
        dq_i_rise = '0; dq_i_fall = '0;
        for (int i = 0; i < NW; i++) mem[i] = 16'hXXXX;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n && !ck_en && !busy && !rvalid && !dev_rst_n, "R1",
            48'({cs_n, ck_en, busy, rvalid, dev_rst_n}), 48'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_rst_n, "R1", 48'(dev_rst_n), 1);
        // R2 R4: write sweep over all addresses
        for (int a = 0; a < NW; a++) begin
            xfer(1'b0, 1'b1, AW'(a), pat(a), td, tv, g);
            chk(td == LAT + 3, "R7", 48'(td), 48'(LAT + 3));
        end
        // R6: read sweep with latency and byte order
        for (int a = NW - 1; a >= 0; a--) begin
            xfer(1'b1, 1'b0, AW'(a), 16'h0, td, tv, g);
            chk(tv == LAT + 2, "R6", 48'(tv), 48'(LAT + 2));
            chk(g == pat(a), "R6", 48'(g), 48'(pat(a)));
        end
        // R10: read wins over write
        xfer(1'b1, 1'b1, AW'(5), 16'hDEAD, td, tv, g);
        chk(tv == LAT + 2 && g == pat(5), "R10", 48'(g), 48'(pat(5)));
        // R9: request during busy ignored
        c0 = txn;
        exp_rd = 1'b0; exp_addr = AW'(3);
        wr_req = 1'b1; addr = AW'(3); wdata = 16'h1234;
        @(negedge clk); wr_req = 1'b0;
        repeat (4) @(negedge clk);
        wr_req = 1'b1; addr = AW'(7); wdata = 16'hBEEF;
        @(negedge clk); wr_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(txn == c0 + 1, "R9", 48'(txn), 48'(c0 + 1));
        xfer(1'b1, 1'b0, AW'(7), 16'h0, td, tv, g);
        chk(g == pat(7), "R9", 48'(g), 48'(pat(7)));
        xfer(1'b1, 1'b0, AW'(3), 16'h0, td, tv, g);
        chk(g == 16'h1234, "R9", 48'(g), 48'h1234);
        // R7: held request still lets busy drop between transactions
        c0 = txn; exp_rd = 1'b1; exp_addr = AW'(9);
        rd_req = 1'b1; addr = AW'(9);
        begin
            int nv = 0, low = 0;
            for (int n = 0; n < 60 && nv < 2; n++) begin
                @(negedge clk);
                if (!busy && n > 0) low++;
                if (rvalid) begin
                    nv++;
                    chk(rdata == pat(9), "R6", 48'(rdata), 48'(pat(9)));
                end
            end
            rd_req = 1'b0;
            chk(low >= 1, "R7", 48'(low), 1);
        end
        repeat (4) @(negedge clk);
        chk(txn == c0 + 2, "R7", 48'(txn), 48'(c0 + 2));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule